// File: doc/BRIEF.md
# Decode Operand Hazard Resolver

This block sits in the decode stage of a five-stage in-order pipeline. It takes the instruction at the head of the fetch buffer and resolves its two source operands. For each operand it picks one of three outcomes: the register-file value, a value forwarded from a younger in-flight producer, or a hold request. The block has no state of its own. Each cycle it sees the destination tags of the occupants of the decode, execute and memory buffers, and the live result that execute is producing in the current cycle before that result is registered.

The parameter `FWD_PRE` selects between two forwarding schemes. With `FWD_PRE = 0` the block forwards only from registered buffers. Any writer still in the decode buffer forces a hold, and this includes a load-constant instruction. With `FWD_PRE = 1` the block also forwards execute's live output. The decode-buffer occupant is the instruction execute is working on in that cycle, so the decode buffer is never a cause of a hold. A load-constant passes through execute unchanged and is forwarded from execute's live output.

Each producer reports whether its value is complete. A load sitting in the execute buffer has not read memory yet, so its value is incomplete. The memory buffer's value is always complete. When several producers write the same register, the youngest one wins. The order from youngest is: live execute result (or the decode buffer), then the execute buffer, then the memory buffer, then the register file.

Top module: `hzd_fwd_unit`

## Requirements
- R1: A used operand whose register number matches no valid writing producer takes the register-file value, and the hold output stays 0.
- R2: With FWD_PRE=0, a used operand that matches a valid writer in the decode buffer raises hold. This applies to a load-constant as well.
- R3: A match in the execute buffer with no younger match forwards ebuf_val when ebuf_rdy is 1. When ebuf_rdy is 0 it raises hold.
- R4: A match in the memory buffer with no younger match forwards mbuf_val and does not raise hold.
- R5: Among several matching producers, the youngest decides the outcome. The order is live/decode buffer, then execute buffer, then memory buffer.
- R6: With FWD_PRE=1, a match on execute's live output with live_rdy=1 forwards live_val. The decode-buffer inputs then have no effect on any output.
- R7: With FWD_PRE=1, a match on execute's live output with live_rdy=0 raises hold.
- R8: The two operands are resolved independently and hold is the OR of their hold conditions. An operand whose use flag is 0 never raises hold.
- R9: A producer whose valid or write-enable flag is 0 is never matched.
- R10: While hold is 1, both operand outputs carry their register-file values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| use_a | input | 1 | Head instruction reads operand A |
| src_a | input | REG_W | Register number of operand A |
| rf_a | input | DATA_W | Register-file value for operand A |
| use_b | input | 1 | Head instruction reads operand B |
| src_b | input | REG_W | Register number of operand B |
| rf_b | input | DATA_W | Register-file value for operand B |
| live_vld | input | 1 | Execute is processing an instruction this cycle |
| live_wr | input | 1 | That instruction writes a register |
| live_dst | input | REG_W | Its destination register |
| live_rdy | input | 1 | Its result is complete this cycle |
| live_val | input | DATA_W | Its result |
| dbuf_vld | input | 1 | Decode buffer occupied |
| dbuf_wr | input | 1 | Decode buffer occupant writes a register |
| dbuf_dst | input | REG_W | Its destination register |
| ebuf_vld | input | 1 | Execute buffer occupied |
| ebuf_wr | input | 1 | Execute buffer occupant writes a register |
| ebuf_dst | input | REG_W | Its destination register |
| ebuf_rdy | input | 1 | Its value is complete (0 for a pending load) |
| ebuf_val | input | DATA_W | Its value |
| mbuf_vld | input | 1 | Memory buffer occupied |
| mbuf_wr | input | 1 | Memory buffer occupant writes a register |
| mbuf_dst | input | REG_W | Its destination register |
| mbuf_val | input | DATA_W | Its value |
| opnd_a | output | DATA_W | Resolved operand A |
| opnd_b | output | DATA_W | Resolved operand B |
| hold | output | 1 | Decode must not advance this cycle |

## Verification
The assertions assume the live-execute inputs describe the same instruction as the decode-buffer inputs. They also assume all inputs settle together once per cycle, because the checks are evaluated on combinational values. The stimulus applies each input pattern in one step just after a clock edge and compares the outputs half a period later. Register numbers are drawn from a small range so that matches, multiple matches and misses all occur often. Both forwarding schemes are driven by the same stimulus, so any difference between the two outputs comes only from the scheme.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Outcome chosen for one source operand.
    typedef enum logic [2:0] {
        PICK_RF     = 3'd0,
        PICK_LIVE   = 3'd1,
        PICK_EXBUF  = 3'd2,
        PICK_MEMBUF = 3'd3,
        PICK_HOLD   = 3'd4
    } pick_t;

    // Producer slots, youngest first.
    localparam int PR_LIVE = 0;
    localparam int PR_DBUF = 1;
    localparam int PR_EBUF = 2;
    localparam int PR_MBUF = 3;
    localparam int N_PROD  = 4;
    localparam int N_OPND  = 2;

endpackage

// File: rtl/hzd_probe.sv
module hzd_probe #(
    parameter int REG_W = 5
) (
    input  logic             use_src,
    input  logic [REG_W-1:0] src,
    input  logic             p_vld,
    input  logic             p_wr,
    input  logic [REG_W-1:0] p_dst,
    output logic             hit
);
    always_comb begin
        hit = use_src && p_vld && p_wr && (p_dst == src);
    end
endmodule

// File: rtl/hzd_pick.sv
module hzd_pick
    import hzd_pkg::*;
#(
    parameter bit FWD_PRE = 1'b1
) (
    input  logic [N_PROD-1:0] hits,
    input  logic              live_rdy,
    input  logic              ebuf_rdy,
    output pick_t             pick
);
    always_comb begin
        if (FWD_PRE && hits[PR_LIVE]) begin
            pick = live_rdy ? PICK_LIVE : PICK_HOLD;
        end else if (!FWD_PRE && hits[PR_DBUF]) begin
            pick = PICK_HOLD;
        end else if (hits[PR_EBUF]) begin
            pick = ebuf_rdy ? PICK_EXBUF : PICK_HOLD;
        end else if (hits[PR_MBUF]) begin
            pick = PICK_MEMBUF;
        end else begin
            pick = PICK_RF;
        end
    end
endmodule

// File: rtl/hzd_opmux.sv
module hzd_opmux
    import hzd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  pick_t             pick,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] live_val,
    input  logic [DATA_W-1:0] ebuf_val,
    input  logic [DATA_W-1:0] mbuf_val,
    output logic [DATA_W-1:0] fwd_val,
    output logic              want_hold
);
    always_comb begin
        want_hold = 1'b0;
        fwd_val   = rf_val;
        unique case (pick)
            PICK_RF:     fwd_val = rf_val;
            PICK_LIVE:   fwd_val = live_val;
            PICK_EXBUF:  fwd_val = ebuf_val;
            PICK_MEMBUF: fwd_val = mbuf_val;
            PICK_HOLD:   want_hold = 1'b1;
            default:     want_hold = 1'b1;
        endcase
    end
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
    import hzd_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int DATA_W  = 32,
    parameter bit FWD_PRE = 1'b1
) (
    input  logic              use_a,
    input  logic [REG_W-1:0]  src_a,
    input  logic [DATA_W-1:0] rf_a,
    input  logic              use_b,
    input  logic [REG_W-1:0]  src_b,
    input  logic [DATA_W-1:0] rf_b,
    input  logic              live_vld,
    input  logic              live_wr,
    input  logic [REG_W-1:0]  live_dst,
    input  logic              live_rdy,
    input  logic [DATA_W-1:0] live_val,
    input  logic              dbuf_vld,
    input  logic              dbuf_wr,
    input  logic [REG_W-1:0]  dbuf_dst,
    input  logic              ebuf_vld,
    input  logic              ebuf_wr,
    input  logic [REG_W-1:0]  ebuf_dst,
    input  logic              ebuf_rdy,
    input  logic [DATA_W-1:0] ebuf_val,
    input  logic              mbuf_vld,
    input  logic              mbuf_wr,
    input  logic [REG_W-1:0]  mbuf_dst,
    input  logic [DATA_W-1:0] mbuf_val,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic              hold
);
    // Producer tag arrays, youngest first.
    logic [N_PROD-1:0]             p_vld;
    logic [N_PROD-1:0]             p_wr;
    logic [N_PROD-1:0][REG_W-1:0]  p_dst;

    // Operand request arrays.
    logic [N_OPND-1:0]              o_use;
    logic [N_OPND-1:0][REG_W-1:0]   o_src;
    logic [N_OPND-1:0][DATA_W-1:0]  o_rf;
    logic [N_OPND-1:0][DATA_W-1:0]  o_fwd;
    logic [N_OPND-1:0]              o_hold;
    logic [N_OPND-1:0][N_PROD-1:0]  o_hits;
    pick_t                          o_pick [N_OPND];

    always_comb begin
        p_vld[PR_LIVE] = live_vld;  p_wr[PR_LIVE] = live_wr;  p_dst[PR_LIVE] = live_dst;
        p_vld[PR_DBUF] = dbuf_vld;  p_wr[PR_DBUF] = dbuf_wr;  p_dst[PR_DBUF] = dbuf_dst;
        p_vld[PR_EBUF] = ebuf_vld;  p_wr[PR_EBUF] = ebuf_wr;  p_dst[PR_EBUF] = ebuf_dst;
        p_vld[PR_MBUF] = mbuf_vld;  p_wr[PR_MBUF] = mbuf_wr;  p_dst[PR_MBUF] = mbuf_dst;
        o_use[0] = use_a;  o_src[0] = src_a;  o_rf[0] = rf_a;
        o_use[1] = use_b;  o_src[1] = src_b;  o_rf[1] = rf_b;
    end

    for (genvar op = 0; op < N_OPND; op++) begin : g_opnd
        for (genvar pr = 0; pr < N_PROD; pr++) begin : g_prod
            hzd_probe #(.REG_W(REG_W)) u_probe (
                .use_src (o_use[op]),
                .src     (o_src[op]),
                .p_vld   (p_vld[pr]),
                .p_wr    (p_wr[pr]),
                .p_dst   (p_dst[pr]),
                .hit     (o_hits[op][pr])
            );
        end

        hzd_pick #(.FWD_PRE(FWD_PRE)) u_pick (
            .hits     (o_hits[op]),
            .live_rdy (live_rdy),
            .ebuf_rdy (ebuf_rdy),
            .pick     (o_pick[op])
        );

        hzd_opmux #(.DATA_W(DATA_W)) u_mux (
            .pick      (o_pick[op]),
            .rf_val    (o_rf[op]),
            .live_val  (live_val),
            .ebuf_val  (ebuf_val),
            .mbuf_val  (mbuf_val),
            .fwd_val   (o_fwd[op]),
            .want_hold (o_hold[op])
        );
    end

    // A hold on either operand freezes both at register-file values.
    always_comb begin
        hold   = |o_hold;
        opnd_a = hold ? rf_a : o_fwd[0];
        opnd_b = hold ? rf_b : o_fwd[1];
    end
endmodule

// File: rtl/hzd_fwd_chk.sv
module hzd_fwd_chk #(
    parameter int REG_W   = 5,
    parameter int DATA_W  = 32,
    parameter bit FWD_PRE = 1'b1
) (
    input logic              use_a,
    input logic [REG_W-1:0]  src_a,
    input logic [DATA_W-1:0] rf_a,
    input logic              use_b,
    input logic [DATA_W-1:0] rf_b,
    input logic              live_vld,
    input logic              live_wr,
    input logic [REG_W-1:0]  live_dst,
    input logic              live_rdy,
    input logic [DATA_W-1:0] live_val,
    input logic              dbuf_vld,
    input logic              dbuf_wr,
    input logic [REG_W-1:0]  dbuf_dst,
    input logic              ebuf_vld,
    input logic              ebuf_wr,
    input logic [REG_W-1:0]  ebuf_dst,
    input logic              ebuf_rdy,
    input logic              mbuf_vld,
    input logic              mbuf_wr,
    input logic [REG_W-1:0]  mbuf_dst,
    input logic [DATA_W-1:0] mbuf_val,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              hold
);
    logic m_live, m_dbuf, m_ebuf, m_mbuf, younger_e;

    always_comb begin
        m_live    = use_a && live_vld && live_wr && live_dst == src_a;
        m_dbuf    = use_a && dbuf_vld && dbuf_wr && dbuf_dst == src_a;
        m_ebuf    = use_a && ebuf_vld && ebuf_wr && ebuf_dst == src_a;
        m_mbuf    = use_a && mbuf_vld && mbuf_wr && mbuf_dst == src_a;
        younger_e = FWD_PRE ? m_live : m_dbuf;

        if (!use_a && !use_b)
            AST_UNUSED_NO_HOLD: assert (!hold) else $error("unused operands held"); // R8
        if (use_a && !m_live && !m_dbuf && !m_ebuf && !m_mbuf && !hold)
            AST_PASS_RF: assert (opnd_a == rf_a) else $error("opnd_a not rf"); // R1
        if (hold)
            AST_HOLD_RF: assert (opnd_a == rf_a && opnd_b == rf_b) else $error("held operand not rf"); // R10
        if (!FWD_PRE && m_dbuf)
            AST_DBUF_HOLD: assert (hold) else $error("decode buffer writer not held"); // R2
        if (m_ebuf && !younger_e && !ebuf_rdy)
            AST_EBUF_PENDING: assert (hold) else $error("pending ebuf not held"); // R3
        if (m_mbuf && !m_ebuf && !younger_e && !hold)
            AST_MBUF_FWD: assert (opnd_a == mbuf_val) else $error("mbuf not forwarded"); // R4
        if (FWD_PRE && m_live && live_rdy && !hold)
            AST_LIVE_FWD: assert (opnd_a == live_val) else $error("live not forwarded"); // R6
        if (FWD_PRE && m_live && !live_rdy)
            AST_LIVE_PENDING: assert (hold) else $error("pending live not held"); // R7
    end
endmodule

bind hzd_fwd_unit hzd_fwd_chk #(.REG_W(REG_W), .DATA_W(DATA_W), .FWD_PRE(FWD_PRE)) u_chk (
    .use_a(use_a), .src_a(src_a), .rf_a(rf_a), .use_b(use_b), .rf_b(rf_b),
    .live_vld(live_vld), .live_wr(live_wr), .live_dst(live_dst), .live_rdy(live_rdy),
    .live_val(live_val), .dbuf_vld(dbuf_vld), .dbuf_wr(dbuf_wr), .dbuf_dst(dbuf_dst),
    .ebuf_vld(ebuf_vld), .ebuf_wr(ebuf_wr), .ebuf_dst(ebuf_dst), .ebuf_rdy(ebuf_rdy),
    .mbuf_vld(mbuf_vld), .mbuf_wr(mbuf_wr), .mbuf_dst(mbuf_dst), .mbuf_val(mbuf_val),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .hold(hold)
);

// File: tb/tb_hzd_fwd_unit.sv
module tb_hzd_fwd_unit;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          use_a, use_b, live_vld, live_wr, live_rdy;
    logic          dbuf_vld, dbuf_wr, ebuf_vld, ebuf_wr, ebuf_rdy, mbuf_vld, mbuf_wr;
    logic [RW-1:0] src_a, src_b, live_dst, dbuf_dst, ebuf_dst, mbuf_dst;
    logic [DW-1:0] rf_a, rf_b, live_val, ebuf_val, mbuf_val;
    logic [DW-1:0] pa, pb, ba, bb;
    logic          ph, bh;

    hzd_fwd_unit #(.REG_W(RW), .DATA_W(DW), .FWD_PRE(1'b1)) dut (
        .use_a, .src_a, .rf_a, .use_b, .src_b, .rf_b,
        .live_vld, .live_wr, .live_dst, .live_rdy, .live_val,
        .dbuf_vld, .dbuf_wr, .dbuf_dst,
        .ebuf_vld, .ebuf_wr, .ebuf_dst, .ebuf_rdy, .ebuf_val,
        .mbuf_vld, .mbuf_wr, .mbuf_dst, .mbuf_val,
        .opnd_a(pa), .opnd_b(pb), .hold(ph));

    hzd_fwd_unit #(.REG_W(RW), .DATA_W(DW), .FWD_PRE(1'b0)) dut_buf (
        .use_a, .src_a, .rf_a, .use_b, .src_b, .rf_b,
        .live_vld, .live_wr, .live_dst, .live_rdy, .live_val,
        .dbuf_vld, .dbuf_wr, .dbuf_dst,
        .ebuf_vld, .ebuf_wr, .ebuf_dst, .ebuf_rdy, .ebuf_val,
        .mbuf_vld, .mbuf_wr, .mbuf_dst, .mbuf_val,
        .opnd_a(ba), .opnd_b(bb), .hold(bh));

    typedef struct {
        logic [DW-1:0] ea_p, eb_p, ea_b, eb_b;
        logic          eh_p, eh_b;
        string         tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   drv_done = 1'b0;

    // Returns {hold, value} for one operand per the requirements.
    function automatic logic [DW:0] model_op(bit pre, logic u, logic [RW-1:0] s, logic [DW-1:0] rf);
        logic hl, hd, he, hm;
        hl = live_vld && live_wr && live_dst == s;
        hd = dbuf_vld && dbuf_wr && dbuf_dst == s;
        he = ebuf_vld && ebuf_wr && ebuf_dst == s;
        hm = mbuf_vld && mbuf_wr && mbuf_dst == s;
        if (!u) return {1'b0, rf};
        if (pre && hl) return live_rdy ? {1'b0, live_val} : {1'b1, rf};
        if (!pre && hd) return {1'b1, rf};
        if (he) return ebuf_rdy ? {1'b0, ebuf_val} : {1'b1, rf};
        if (hm) return {1'b0, mbuf_val};
        return {1'b0, rf};
    endfunction

    task automatic push_exp(string tag);
        exp_t e;
        logic [DW:0] ra, rb;
        ra = model_op(1'b1, use_a, src_a, rf_a);
        rb = model_op(1'b1, use_b, src_b, rf_b);
        e.eh_p = ra[DW] | rb[DW];
        e.ea_p = e.eh_p ? rf_a : ra[DW-1:0];
        e.eb_p = e.eh_p ? rf_b : rb[DW-1:0];
        ra = model_op(1'b0, use_a, src_a, rf_a);
        rb = model_op(1'b0, use_b, src_b, rf_b);
        e.eh_b = ra[DW] | rb[DW];
        e.ea_b = e.eh_b ? rf_a : ra[DW-1:0];
        e.eb_b = e.eh_b ? rf_b : rb[DW-1:0];
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic clear_prod();
        live_vld = 0; live_wr = 0; live_dst = 0; live_rdy = 1; live_val = 32'hAAAA0001;
        dbuf_vld = 0; dbuf_wr = 0; dbuf_dst = 0;
        ebuf_vld = 0; ebuf_wr = 0; ebuf_dst = 0; ebuf_rdy = 1; ebuf_val = 32'hEEEE0002;
        mbuf_vld = 0; mbuf_wr = 0; mbuf_dst = 0; mbuf_val = 32'h5555_0003;
        use_a = 1; src_a = 5'd1; rf_a = 32'h0000_1111;
        use_b = 1; src_b = 5'd2; rf_b = 32'h0000_2222;
    endtask

    task automatic apply(string tag);
        push_exp(tag);
        @(posedge clk);
    endtask

    task automatic cmp(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Monitor: compare half a period after each application edge.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp(e.tag, "pre.opnd_a", pa, e.ea_p);
            cmp(e.tag, "pre.opnd_b", pb, e.eb_p);
            cmp(e.tag, "pre.hold", {31'd0, ph}, {31'd0, e.eh_p});
            cmp(e.tag, "buf.opnd_a", ba, e.ea_b);
            cmp(e.tag, "buf.opnd_b", bb, e.eb_b);
            cmp(e.tag, "buf.hold", {31'd0, bh}, {31'd0, e.eh_b});
        end
    end

    // Driver: inputs change only right after a rising edge.
    initial begin
        logic [31:0] lfsr;
        clear_prod();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        apply("R1 reset state, no producers");

        clear_prod(); mbuf_vld = 1; mbuf_wr = 1; mbuf_dst = 5'd7;
        apply("R1 miss on other register");

        clear_prod(); dbuf_vld = 1; dbuf_wr = 1; dbuf_dst = 5'd1;
        live_vld = 1; live_wr = 1; live_dst = 5'd1; live_rdy = 1; live_val = 32'hC0C0_0042;
        apply("R2 R6 load-constant in decode buffer");

        clear_prod(); dbuf_vld = 1; dbuf_wr = 1; dbuf_dst = 5'd2;
        apply("R6 decode buffer ignored in pre mode, held in buf mode");

        clear_prod(); ebuf_vld = 1; ebuf_wr = 1; ebuf_dst = 5'd1; ebuf_rdy = 1;
        apply("R3 execute buffer ready");

        clear_prod(); ebuf_vld = 1; ebuf_wr = 1; ebuf_dst = 5'd2; ebuf_rdy = 0;
        apply("R3 R10 pending load in execute buffer");

        clear_prod(); mbuf_vld = 1; mbuf_wr = 1; mbuf_dst = 5'd2;
        apply("R4 memory buffer forward");

        clear_prod(); mbuf_vld = 1; mbuf_wr = 1; mbuf_dst = 5'd1;
        ebuf_vld = 1; ebuf_wr = 1; ebuf_dst = 5'd1;
        apply("R5 execute beats memory buffer");

        clear_prod(); mbuf_vld = 1; mbuf_wr = 1; mbuf_dst = 5'd1;
        ebuf_vld = 1; ebuf_wr = 1; ebuf_dst = 5'd1; ebuf_rdy = 0;
        live_vld = 1; live_wr = 1; live_dst = 5'd1; live_rdy = 1;
        apply("R5 live beats pending execute buffer");

        clear_prod(); live_vld = 1; live_wr = 1; live_dst = 5'd2; live_rdy = 0;
        apply("R7 live result incomplete");

        clear_prod(); use_a = 0; use_b = 0;
        ebuf_vld = 1; ebuf_wr = 1; ebuf_dst = 5'd1; ebuf_rdy = 0;
        dbuf_vld = 1; dbuf_wr = 1; dbuf_dst = 5'd2;
        apply("R8 unused operands never hold");

        clear_prod(); src_a = 5'd3; src_b = 5'd3;
        ebuf_vld = 1; ebuf_wr = 1; ebuf_dst = 5'd3;
        apply("R8 both operands same register");

        clear_prod(); live_vld = 1; live_wr = 0; live_dst = 5'd1;
        ebuf_vld = 0; ebuf_wr = 1; ebuf_dst = 5'd2; ebuf_rdy = 0;
        dbuf_vld = 1; dbuf_wr = 0; dbuf_dst = 5'd1;
        apply("R9 invalid or non-writing producers");

        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            use_a = lfsr[0]; use_b = lfsr[1];
            src_a = {3'd0, lfsr[3:2]}; src_b = {3'd0, lfsr[5:4]};
            live_vld = lfsr[6]; live_wr = lfsr[7]; live_dst = {3'd0, lfsr[9:8]}; live_rdy = lfsr[10];
            dbuf_vld = lfsr[11]; dbuf_wr = lfsr[12]; dbuf_dst = {3'd0, lfsr[14:13]};
            ebuf_vld = lfsr[15]; ebuf_wr = lfsr[16]; ebuf_dst = {3'd0, lfsr[18:17]}; ebuf_rdy = lfsr[19];
            mbuf_vld = lfsr[20]; mbuf_wr = lfsr[21]; mbuf_dst = {3'd0, lfsr[23:22]};
            rf_a = lfsr ^ 32'h1; rf_b = lfsr ^ 32'h2; live_val = lfsr ^ 32'h3;
            ebuf_val = lfsr ^ 32'h4; mbuf_val = lfsr ^ 32'h5;
            apply("R5 R8 random mix");
        end
        @(posedge clk);
        @(posedge clk);
        drv_done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!drv_done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!drv_done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule